// File: doc/BRIEF.md
# Multithreaded Stage Skid-Buffer Controller

This block runs one pipeline stage that several hardware threads share. Each thread owns a small skid FIFO of instruction sequence numbers and keeps its own status. Each cycle the stage takes at most one instruction from the upstream latch into the FIFO of the thread it belongs to. It issues instructions downstream, oldest first, while the next stage reports free slots. It also tracks stall indications from later stages, trims younger work on a squash, and sends one-cycle block and unblock handshakes toward earlier stages.

All threads share one storage capacity. The stage reports the free space that remains so that the upstream stage can pace itself. Issue is limited per thread per cycle. Threads are served in ascending ID order from one shared downstream budget.

Top module: `skid_stage`

## Requirements
- R1: After reset every thread is Idle, `upFree` equals CAP (6), and no issue lane, block pulse or unblock pulse is asserted. Status codes are 3 bits per thread, with thread t at bits [3t+2:3t]: Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.
- R2: A valid input that is not flagged squashed is appended to the FIFO of thread `inTid`. An input with `inSquashed` set is dropped, and `upFree` does not change.
- R3: `upFree` equals CAP minus the total number of entries held across all thread FIFOs, and it never goes below zero.
- R4: A thread in Idle, Running or Unblocking issues its oldest entries, at most WIDTH (2) per cycle. Lane t*WIDTH+j carries its j-th oldest entry on `issueSeq[8*lane +: 8]`.
- R5: Threads are served in ascending ID order. The total number of lanes issued in a cycle never exceeds `dnFree`.
- R6: Thread t keeps one stall bit per later stage s. Bit index t*LATER+s (LATER=2) of `nextBlock` sets that bit and the same index of `nextUnblock` clears it. Only the s=0 bit, or the thread's `resStall` level, makes the thread stall.
- R7: A stalled thread that is not being squashed becomes Blocked in the next cycle. `blockPulse` is raised for one cycle, and only when the current status is not already Blocked. A Blocked thread issues nothing.
- R8: A Blocked thread whose stall has cleared becomes Unblocking in the next cycle. It issues nothing and raises no pulse in that cycle.
- R9: An Unblocking thread with an empty FIFO raises `unblockPulse` for one cycle and becomes Running. While its FIFO holds entries, it issues as in R4.
- R10: A squash for thread t has priority over its stall. The thread becomes Squashing and raises no block pulse. FIFO entries are removed from the head while their sequence number exceeds the squash number, and removal stops at the first entry that does not. A same-cycle input for t that is younger than the squash number is dropped.
- R11: A Squashing thread with no new squash or stall becomes Unblocking if its FIFO holds entries and Running if it is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Upstream latch holds an instruction |
| inTid | input | 1 | Thread of the incoming instruction |
| inSeq | input | 8 | Sequence number of the incoming instruction |
| inSquashed | input | 1 | Incoming instruction already marked squashed |
| squashValid | input | 2 | Per-thread squash request |
| squashSeq | input | 16 | Per-thread squash sequence number |
| nextBlock | input | 4 | Block indications from later stages, per thread and stage |
| nextUnblock | input | 4 | Unblock indications from later stages, per thread and stage |
| resStall | input | 2 | Per-thread pending resource stall |
| dnFree | input | 3 | Free slots in the downstream stage this cycle |
| issueValid | output | 4 | Issue lane valid, thread-major |
| issueSeq | output | 32 | Sequence number on each issue lane |
| blockPulse | output | 2 | One-cycle block handshake toward the previous stage |
| unblockPulse | output | 2 | One-cycle unblock handshake toward the previous stage |
| upFree | output | 3 | Free shared skid capacity |
| threadStatus | output | 6 | Current status of each thread |

## Verification
The assertions assume that the upstream stage never offers an instruction when `upFree` is zero or when the target thread's FIFO is full. They also assume that sequence numbers grow without wrapping inside a run. The stimulus drives at most one instruction per cycle and keeps total occupancy well below the shared capacity. It uses small, increasing sequence numbers, so every squash comparison is a plain unsigned one. Stall and squash inputs are raised for single cycles, except where a level stall is held on purpose, which keeps each status transition tied to one known cause.

// File: rtl/skid_pkg.sv
package skid_pkg;
  localparam int NTHREADS     = 2;
  localparam int FIFO_DEPTH   = 4;   // power of two
  localparam int SEQ_BITS     = 8;
  localparam int ISSUE_W      = 2;
  localparam int BUF_CAP      = 6;
  localparam int LATER_STAGES = 2;
  localparam int CNT_BITS     = $clog2(FIFO_DEPTH + 1);

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RUN        = 3'd1,
    ST_BLOCKED    = 3'd2,
    ST_UNBLOCKING = 3'd3,
    ST_SQUASHING  = 3'd4
  } status_e;

  // Control-to-datapath strobes: one push flag and one pop count per thread.
  typedef struct packed {
    logic [NTHREADS-1:0]               push;
    logic [NTHREADS-1:0][CNT_BITS-1:0] pop;
  } strobe_t;
endpackage

// File: rtl/skid_store.sv
module skid_store #(
  parameter int THREADS = skid_pkg::NTHREADS,
  parameter int DEPTH   = skid_pkg::FIFO_DEPTH,
  parameter int SEQ_W   = skid_pkg::SEQ_BITS,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  skid_pkg::strobe_t                        strobe,
  input  logic [SEQ_W-1:0]                         wrSeq,
  output logic [THREADS-1:0][CNT_W-1:0]            count,
  output logic [THREADS-1:0][DEPTH-1:0][SEQ_W-1:0] view
);
  localparam int PTR_W = $clog2(DEPTH);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [SEQ_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rdPtr;
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] wrPtr;

    assign wrPtr = rdPtr + cnt[PTR_W-1:0];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        rdPtr <= rdPtr + strobe.pop[t][PTR_W-1:0];
        cnt   <= cnt + CNT_W'(strobe.push[t]) - strobe.pop[t];
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.push[t]) mem[wrPtr] <= wrSeq;
    end

    assign count[t] = cnt;
    for (genvar i = 0; i < DEPTH; i++) begin : g_view
      assign view[t][i] = mem[rdPtr + PTR_W'(i)];
    end
  end
endmodule

// File: rtl/skid_ctrl.sv
module skid_ctrl #(
  parameter int THREADS = skid_pkg::NTHREADS,
  parameter int DEPTH   = skid_pkg::FIFO_DEPTH,
  parameter int SEQ_W   = skid_pkg::SEQ_BITS,
  parameter int WIDTH   = skid_pkg::ISSUE_W,
  parameter int CAP     = skid_pkg::BUF_CAP,
  parameter int LATER   = skid_pkg::LATER_STAGES,
  parameter int CNT_W   = $clog2(DEPTH + 1),
  parameter int TID_W   = $clog2(THREADS),
  parameter int DN_W    = $clog2(THREADS * WIDTH + 1),
  parameter int FREE_W  = $clog2(CAP + 1)
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     inValid,
  input  logic [TID_W-1:0]                         inTid,
  input  logic [SEQ_W-1:0]                         inSeq,
  input  logic                                     inSquashed,
  input  logic [THREADS-1:0]                       squashValid,
  input  logic [THREADS-1:0][SEQ_W-1:0]            squashSeq,
  input  logic [THREADS-1:0][LATER-1:0]            nextBlock,
  input  logic [THREADS-1:0][LATER-1:0]            nextUnblock,
  input  logic [THREADS-1:0]                       resStall,
  input  logic [DN_W-1:0]                          dnFree,
  input  logic [THREADS-1:0][CNT_W-1:0]            count,
  input  logic [THREADS-1:0][DEPTH-1:0][SEQ_W-1:0] view,
  output skid_pkg::strobe_t                        strobe,
  output logic [THREADS*WIDTH-1:0]                 issueValid,
  output logic [THREADS*WIDTH-1:0][SEQ_W-1:0]      issueSeq,
  output logic [THREADS-1:0]                       blockPulse,
  output logic [THREADS-1:0]                       unblockPulse,
  output logic [FREE_W-1:0]                        upFree,
  output logic [THREADS*3-1:0]                     threadStatus
);
  import skid_pkg::*;

  status_e statusQ [THREADS];
  status_e statusD [THREADS];
  logic [THREADS-1:0][LATER-1:0] stallQ, stallD;

  always_comb begin
    int  budget;
    int  total;
    logic go;
    logic canIssue;

    // Stall bits: a block sets, an unblock clears (unblock wins).
    stallD = stallQ;
    for (int t = 0; t < THREADS; t++)
      for (int s = 0; s < LATER; s++) begin
        if (nextBlock[t][s])   stallD[t][s] = 1'b1;
        if (nextUnblock[t][s]) stallD[t][s] = 1'b0;
      end

    total = 0;
    for (int t = 0; t < THREADS; t++) total += int'(count[t]);
    upFree = FREE_W'(CAP - total);

    budget       = int'(dnFree);
    strobe       = '0;
    issueValid   = '0;
    issueSeq     = '0;
    blockPulse   = '0;
    unblockPulse = '0;

    for (int t = 0; t < THREADS; t++) begin
      statusD[t] = statusQ[t];
      canIssue   = 1'b0;
      go         = 1'b1;
      if (squashValid[t]) begin
        statusD[t] = ST_SQUASHING;
        for (int i = 0; i < DEPTH; i++) begin
          if (go && i < int'(count[t]) && view[t][i] > squashSeq[t])
            strobe.pop[t] = strobe.pop[t] + CNT_W'(1);
          else
            go = 1'b0;
        end
      end else if (stallD[t][0] || resStall[t]) begin
        statusD[t]    = ST_BLOCKED;
        blockPulse[t] = (statusQ[t] != ST_BLOCKED);
      end else begin
        case (statusQ[t])
          ST_BLOCKED:   statusD[t] = ST_UNBLOCKING;
          ST_SQUASHING: statusD[t] = (count[t] != '0) ? ST_UNBLOCKING : ST_RUN;
          ST_UNBLOCKING: begin
            if (count[t] == '0) begin
              statusD[t]      = ST_RUN;
              unblockPulse[t] = 1'b1;
            end else begin
              canIssue = 1'b1;
            end
          end
          default: canIssue = 1'b1;
        endcase
      end

      if (canIssue) begin
        for (int j = 0; j < WIDTH; j++) begin
          if (j < int'(count[t]) && budget > 0) begin
            issueValid[t*WIDTH+j] = 1'b1;
            issueSeq[t*WIDTH+j]   = view[t][j];
            strobe.pop[t]         = strobe.pop[t] + CNT_W'(1);
            budget--;
          end
        end
      end
    end

    if (inValid && !inSquashed &&
        !(squashValid[inTid] && inSeq > squashSeq[inTid]) &&
        int'(count[inTid]) < DEPTH && total < CAP)
      strobe.push[inTid] = 1'b1;

    for (int t = 0; t < THREADS; t++) threadStatus[t*3 +: 3] = statusQ[t];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallQ <= '0;
      for (int t = 0; t < THREADS; t++) statusQ[t] <= ST_IDLE;
    end else begin
      stallQ <= stallD;
      for (int t = 0; t < THREADS; t++) statusQ[t] <= statusD[t];
    end
  end
endmodule

// File: rtl/skid_stage.sv
module skid_stage #(
  parameter int THREADS = skid_pkg::NTHREADS,
  parameter int DEPTH   = skid_pkg::FIFO_DEPTH,
  parameter int SEQ_W   = skid_pkg::SEQ_BITS,
  parameter int WIDTH   = skid_pkg::ISSUE_W,
  parameter int CAP     = skid_pkg::BUF_CAP,
  parameter int LATER   = skid_pkg::LATER_STAGES,
  parameter int CNT_W   = $clog2(DEPTH + 1),
  parameter int TID_W   = $clog2(THREADS),
  parameter int DN_W    = $clog2(THREADS * WIDTH + 1),
  parameter int FREE_W  = $clog2(CAP + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  input  logic [TID_W-1:0]               inTid,
  input  logic [SEQ_W-1:0]               inSeq,
  input  logic                           inSquashed,
  input  logic [THREADS-1:0]             squashValid,
  input  logic [THREADS*SEQ_W-1:0]       squashSeq,
  input  logic [THREADS*LATER-1:0]       nextBlock,
  input  logic [THREADS*LATER-1:0]       nextUnblock,
  input  logic [THREADS-1:0]             resStall,
  input  logic [DN_W-1:0]                dnFree,
  output logic [THREADS*WIDTH-1:0]       issueValid,
  output logic [THREADS*WIDTH*SEQ_W-1:0] issueSeq,
  output logic [THREADS-1:0]             blockPulse,
  output logic [THREADS-1:0]             unblockPulse,
  output logic [FREE_W-1:0]              upFree,
  output logic [THREADS*3-1:0]           threadStatus
);
  skid_pkg::strobe_t                        strobe;
  logic [THREADS-1:0][CNT_W-1:0]            count;
  logic [THREADS-1:0][DEPTH-1:0][SEQ_W-1:0] view;

  skid_ctrl #(
    .THREADS(THREADS), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .WIDTH(WIDTH),
    .CAP(CAP), .LATER(LATER), .CNT_W(CNT_W), .TID_W(TID_W),
    .DN_W(DN_W), .FREE_W(FREE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTid(inTid), .inSeq(inSeq),
    .inSquashed(inSquashed), .squashValid(squashValid), .squashSeq(squashSeq),
    .nextBlock(nextBlock), .nextUnblock(nextUnblock), .resStall(resStall),
    .dnFree(dnFree), .count(count), .view(view), .strobe(strobe),
    .issueValid(issueValid), .issueSeq(issueSeq), .blockPulse(blockPulse),
    .unblockPulse(unblockPulse), .upFree(upFree), .threadStatus(threadStatus)
  );

  skid_store #(
    .THREADS(THREADS), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSeq(inSeq),
    .count(count), .view(view)
  );
endmodule

// File: rtl/skid_stage_chk.sv
module skid_stage_chk #(
  parameter int THREADS = skid_pkg::NTHREADS,
  parameter int WIDTH   = skid_pkg::ISSUE_W,
  parameter int CAP     = skid_pkg::BUF_CAP,
  parameter int DN_W    = $clog2(THREADS * WIDTH + 1),
  parameter int FREE_W  = $clog2(CAP + 1)
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [THREADS-1:0]       squashValid,
  input logic [DN_W-1:0]          dnFree,
  input logic [THREADS*WIDTH-1:0] issueValid,
  input logic [THREADS-1:0]       blockPulse,
  input logic [THREADS-1:0]       unblockPulse,
  input logic [FREE_W-1:0]        upFree,
  input logic [THREADS*3-1:0]     threadStatus
);
  import skid_pkg::*;

  a_r3_capacity: assert property (@(posedge clk) disable iff (!rstN)
    int'(upFree) <= CAP);

  a_r5_budget: assert property (@(posedge clk) disable iff (!rstN)
    $countones(issueValid) <= int'(dnFree));

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic [2:0] st;
    assign st = threadStatus[t*3 +: 3];

    a_r7_block_enters: assert property (@(posedge clk) disable iff (!rstN)
      blockPulse[t] |=> st == ST_BLOCKED);

    a_r7_block_once: assert property (@(posedge clk) disable iff (!rstN)
      blockPulse[t] |-> st != ST_BLOCKED);

    a_r7_blocked_silent: assert property (@(posedge clk) disable iff (!rstN)
      st == ST_BLOCKED |-> issueValid[t*WIDTH +: WIDTH] == '0);

    a_r9_unblock_exit: assert property (@(posedge clk) disable iff (!rstN)
      unblockPulse[t] |-> st == ST_UNBLOCKING);

    a_r9_unblock_run: assert property (@(posedge clk) disable iff (!rstN)
      unblockPulse[t] |=> st == ST_RUN);

    a_r10_squash_state: assert property (@(posedge clk) disable iff (!rstN)
      squashValid[t] |=> st == ST_SQUASHING);

    a_r10_squash_no_block: assert property (@(posedge clk) disable iff (!rstN)
      squashValid[t] |-> !blockPulse[t]);

    a_r11_squash_leaves: assert property (@(posedge clk) disable iff (!rstN)
      (st == ST_SQUASHING && !squashValid[t]) |=> st != ST_SQUASHING);
  end
endmodule

bind skid_stage skid_stage_chk #(
  .THREADS(THREADS), .WIDTH(WIDTH), .CAP(CAP), .DN_W(DN_W), .FREE_W(FREE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .squashValid(squashValid), .dnFree(dnFree),
  .issueValid(issueValid), .blockPulse(blockPulse),
  .unblockPulse(unblockPulse), .upFree(upFree), .threadStatus(threadStatus)
);

// File: tb/skid_stage_test.sv
module skid_stage_test;
  localparam int THREADS = 2;
  localparam int WIDTH   = 2;
  localparam int SEQ_W   = 8;
  localparam int LANES   = THREADS * WIDTH;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   inValid = 1'b0;
  logic [0:0]             inTid = '0;
  logic [SEQ_W-1:0]       inSeq = '0;
  logic                   inSquashed = 1'b0;
  logic [1:0]             squashValid = '0;
  logic [15:0]            squashSeq = '0;
  logic [3:0]             nextBlock = '0;
  logic [3:0]             nextUnblock = '0;
  logic [1:0]             resStall = '0;
  logic [2:0]             dnFree = '0;
  logic [LANES-1:0]       issueValid;
  logic [LANES*SEQ_W-1:0] issueSeq;
  logic [1:0]             blockPulse;
  logic [1:0]             unblockPulse;
  logic [2:0]             upFree;
  logic [5:0]             threadStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int expQ [THREADS][$];

  always #2 clk = ~clk;

  skid_stage uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTid(inTid), .inSeq(inSeq),
    .inSquashed(inSquashed), .squashValid(squashValid), .squashSeq(squashSeq),
    .nextBlock(nextBlock), .nextUnblock(nextUnblock), .resStall(resStall),
    .dnFree(dnFree), .issueValid(issueValid), .issueSeq(issueSeq),
    .blockPulse(blockPulse), .unblockPulse(unblockPulse), .upFree(upFree),
    .threadStatus(threadStatus)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int stOf(int t);
    return int'(threadStatus[t*3 +: 3]);
  endfunction

  task automatic nextCycle();
    @(negedge clk);
    inValid = 1'b0; inSquashed = 1'b0; squashValid = '0;
    nextBlock = '0; nextUnblock = '0;
  endtask

  task automatic send(int tid, int seq, bit flagged, bit accepted);
    inValid = 1'b1; inTid = tid[0:0]; inSeq = seq[SEQ_W-1:0]; inSquashed = flagged;
    if (accepted) expQ[tid].push_back(seq);
  endtask

  task automatic modelSquash(int tid, int sq);
    while (expQ[tid].size() > 0 && expQ[tid][0] > sq) void'(expQ[tid].pop_front());
  endtask

  // Scoreboard monitor: every issued lane must match the oldest expected entry (R4).
  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      for (int l = 0; l < LANES; l++) begin
        if (issueValid[l]) begin
          int t;
          int got;
          t = l / WIDTH;
          got = int'(issueSeq[l*SEQ_W +: SEQ_W]);
          checks++;
          if (expQ[t].size() == 0) begin
            errors++;
            $display("FAIL R4 lane %0d got %0d expected none", l, got);
          end else begin
            int exp;
            exp = expQ[t].pop_front();
            if (got != exp) begin
              errors++;
              $display("FAIL R4 lane %0d got %0d expected %0d", l, got, exp);
            end
          end
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 status", int'(threadStatus), 0);
    chk("R1 upFree", int'(upFree), 6);
    chk("R1 issue", int'(issueValid), 0);
    chk("R1 pulses", int'({blockPulse, unblockPulse}), 0);

    // Fill with downstream closed.
    nextCycle(); send(0, 1, 0, 1);
    nextCycle(); send(0, 2, 0, 1);
    nextCycle(); send(0, 3, 0, 1);
    nextCycle(); send(1, 11, 0, 1);
    nextCycle(); send(1, 12, 0, 1);
    nextCycle(); send(1, 13, 1, 0);
    nextCycle(); #1;
    chk("R2 flagged input dropped", int'(upFree), 1);
    chk("R3 shared occupancy", int'(upFree), 1);

    // Budget 3: thread 0 takes 2 lanes, thread 1 takes 1.
    nextCycle(); dnFree = 3; #1;
    chk("R5 ascending budget", int'(issueValid), 4'b0111);
    nextCycle(); #1;
    chk("R4 width limited remainder", int'(issueValid), 4'b0101);
    nextCycle(); dnFree = 0; #1;
    chk("R3 drained", int'(upFree), 6);

    // Block from the next stage.
    nextCycle(); dnFree = 4; send(0, 20, 0, 1); nextBlock[0] = 1'b1; #1;
    chk("R7 block pulse", int'(blockPulse), 1);
    nextCycle(); send(1, 21, 0, 1); #1;
    chk("R7 status blocked", stOf(0), 2);
    chk("R7 no repeat pulse", int'(blockPulse), 0);
    chk("R7 blocked no issue", int'(issueValid[1:0]), 0);
    nextCycle(); nextBlock[3] = 1'b1; #1;
    chk("R6 later stage no block", int'(blockPulse), 0);
    chk("R6 other thread issues", int'(issueValid), 4'b0100);
    nextCycle(); nextUnblock[0] = 1'b1; #1;
    chk("R8 no issue on release", int'(issueValid), 0);
    chk("R8 no pulse on release", int'(unblockPulse), 0);
    nextCycle(); #1;
    chk("R8 status unblocking", stOf(0), 3);
    chk("R9 unblocking issues", int'(issueValid), 4'b0001);
    chk("R9 no early unblock", int'(unblockPulse), 0);
    nextCycle(); #1;
    chk("R9 unblock pulse", int'(unblockPulse), 1);
    nextCycle(); #1;
    chk("R9 status running", stOf(0), 1);
    chk("R6 later bit leaves idle", stOf(1), 0);

    // Resource stall on thread 1.
    nextCycle(); resStall = 2'b10; #1;
    chk("R6 resource stall blocks", int'(blockPulse), 2);
    nextCycle(); #1;
    chk("R7 status blocked t1", stOf(1), 2);
    chk("R7 no repeat pulse t1", int'(blockPulse), 0);
    nextCycle(); resStall = 2'b00; #1;
    chk("R8 no pulse t1", int'(unblockPulse), 0);
    nextCycle(); #1;
    chk("R9 unblock pulse t1", int'(unblockPulse), 2);
    nextCycle(); #1;
    chk("R9 status running t1", stOf(1), 1);

    // Squash handling on thread 1.
    nextCycle(); dnFree = 0; send(1, 30, 0, 1);
    nextCycle(); send(1, 40, 0, 1);
    nextCycle(); squashValid = 2'b10; squashSeq[15:8] = 8'd35; resStall = 2'b10;
    modelSquash(1, 35); send(1, 33, 0, 1); #1;
    chk("R10 squash beats stall", int'(blockPulse), 0);
    nextCycle(); resStall = 2'b00; #1;
    chk("R10 status squashing", stOf(1), 4);
    chk("R10 head stop keeps entries", int'(upFree), 3);
    nextCycle(); #1;
    chk("R11 to unblocking", stOf(1), 3);
    nextCycle(); squashValid = 2'b10; squashSeq[15:8] = 8'd25;
    modelSquash(1, 25); send(1, 60, 0, 0); #1;
    nextCycle(); #1;
    chk("R10 all younger trimmed", int'(upFree), 6);
    chk("R10 status squashing again", stOf(1), 4);
    nextCycle(); #1;
    chk("R11 to running", stOf(1), 1);
    chk("R4 scoreboard empty", expQ[0].size() + expQ[1].size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule